// File: doc/BRIEF.md
# Fail-Safe Clock Monitor

This block guards the primary device clock. A slow, independent sample clock is compared against the primary clock. When the primary stops toggling while it drives the device, the block moves the device-clock multiplexer to the internal oscillator and raises a sticky failure flag. The block never moves back to the failed source by itself. Only a reset, a wake, or a new clock-select write moves the multiplexer away from the internal oscillator.

After reset or wake, monitoring depends on the primary oscillator type:

- **External-clock and RC types:** the primary clock is used and monitored at once.
- **Crystal and resonator types:** the internal oscillator drives the device until the start-up timers report done. During that window, detection is suppressed. A crystal that never starts therefore produces no failure flag; only the start-up status bit stays low.

All control logic runs on the internal oscillator clock. The primary-clock activity and the sample clock each reach it through a two-flop synchronizer.

Top module: `clk_fail_guard`

## Requirements
- R1: After reset with a non-crystal type (`osc_mode` 4, 5 or 6), and the primary running, the outputs settle to `clk_sel`=00 (primary), `osc_stable`=1, `pri_en`=1 and `fail_flag`=0.
- R2: For crystal types (`osc_mode` 0..3), `clk_sel` is 10 (internal) and `osc_stable` is 0 after reset or wake. This holds until `ost_done` is 1 and, for `osc_mode`=3 only, `pll_done` is also 1. Then `clk_sel` becomes 00 and `osc_stable` becomes 1.
- R3: A crystal that never starts (timers never done) yields `fail_flag`=0, `osc_stable`=0 and `clk_sel`=10 indefinitely.
- R4: While the primary keeps toggling, `fail_flag` stays 0 and `clk_sel` stays at its selected value.
- R5: If the primary stops while selected and monitored, then within four sample periods `fail_flag` becomes 1 and `clk_sel` becomes 10.
- R6: After a failure, `clk_sel` stays 10 even if the primary resumes. This holds until a clock-select write or a wake.
- R7: A `flag_clr` pulse clears `fail_flag` and leaves `clk_sel` unchanged.
- R8: A `pm_sel_wr` pulse in run or failed state sets `clk_sel` from `pm_sel`: 00 primary, 01 secondary, 1x internal (10). Only the primary source is monitored, so a stopped primary under a secondary selection sets no flag.
- R9: A `pm_sel_wr` pulse with a non-primary code during crystal start-up drops `pri_en` to 0, and `clk_sel` follows the code.
- R10: With `mon_en`=0, a stopped primary raises no flag and causes no switchover.
- R11: A `wake` pulse restarts the start-up sequence for the current `osc_mode`, and leaves `fail_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| intosc_clk | input | 1 | Internal oscillator clock; clocks all control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_clk | input | 1 | Primary device clock being watched |
| smp_clk | input | 1 | Slow independent sample clock |
| osc_mode | input | 3 | Primary type: 0..3 crystal (3 with PLL), 4..6 external/RC/internal-RC |
| ost_done | input | 1 | Oscillator start-up timer expired |
| pll_done | input | 1 | PLL lock timer expired |
| pm_sel | input | 2 | Requested clock source code |
| pm_sel_wr | input | 1 | One-cycle strobe applying `pm_sel` |
| flag_clr | input | 1 | One-cycle strobe clearing the failure flag |
| mon_en | input | 1 | Enables failure detection |
| wake | input | 1 | One-cycle wake-from-sleep strobe |
| clk_sel | output | 2 | Multiplexer control: 00 primary, 01 secondary, 10 internal |
| pri_en | output | 1 | Primary oscillator enable |
| fail_flag | output | 1 | Sticky failure flag |
| osc_stable | output | 1 | Primary clock started and in use |

## Verification
The assertions assume the following about the inputs:

- `ost_done`, `pll_done` and the strobes are already synchronous to the internal oscillator.
- The strobes last one cycle.
- The sample clock is many internal-oscillator cycles long, so every rising edge is seen once.

The stimulus keeps to these limits. Strobes are driven from the negative edge for exactly one cycle. The sample period is fifty internal cycles. The primary runs at a rate whose toggle the synchronizer can follow. The primary is stopped and restarted only by gating its generator, never by shortening a pulse.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_START = 3'd1,
    ST_ALT   = 3'd2,
    ST_RUN   = 3'd3,
    ST_FAIL  = 3'd4
  } st_e;

  localparam int MODE_W = 3;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_PRI = 2'b00;
  localparam logic [SEL_W-1:0] SEL_SEC = 2'b01;
  localparam logic [SEL_W-1:0] SEL_INT = 2'b10;

  localparam logic [MODE_W-1:0] MODE_PLL = 3'd3;

  function automatic logic is_xtal(logic [MODE_W-1:0] m);
    return (m[MODE_W-1] == 1'b0);
  endfunction

  function automatic logic [SEL_W-1:0] norm_sel(logic [SEL_W-1:0] c);
    return c[1] ? SEL_INT : c;
  endfunction
endpackage

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      logic stg_d;
      if (i == 0) begin : g_first
        always_comb stg_d = d;
      end else begin : g_next
        always_comb stg_d = stg_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= 1'b0;
        else        stg_q[i] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_rst_sync.sv
`timescale 1ns/1ps
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= sh_d;
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/cfg_probe.sv
`timescale 1ns/1ps
module cfg_probe #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pri_rst_n,
  input  logic pri_clk,
  input  logic smp_clk,
  input  logic arm,
  output logic fail_pulse
);
  logic tgl_q, tgl_d;
  logic tgl_s, smp_s;
  logic tgl_prev_q, smp_prev_q;
  logic probe_q, probe_d;
  logic smp_rise, pri_seen;

  // Activity toggle in the primary domain
  always_comb tgl_d = ~tgl_q;
  always_ff @(posedge pri_clk or negedge pri_rst_n) begin
    if (!pri_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= tgl_d;
  end

  cfg_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk(clk), .rst_n(rst_n), .d(tgl_q), .q(tgl_s)
  );
  cfg_sync #(.STAGES(SYNC_STAGES)) u_smp_sync (
    .clk(clk), .rst_n(rst_n), .d(smp_clk), .q(smp_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_prev_q <= 1'b0;
      smp_prev_q <= 1'b0;
    end else begin
      tgl_prev_q <= tgl_s;
      smp_prev_q <= smp_s;
    end
  end

  assign smp_rise = smp_s & ~smp_prev_q;
  assign pri_seen = tgl_s ^ tgl_prev_q;

  always_comb begin
    probe_d = probe_q;
    if (!arm)          probe_d = 1'b0;
    else if (smp_rise) probe_d = 1'b1;
    else if (pri_seen) probe_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) probe_q <= 1'b0;
    else        probe_q <= probe_d;
  end

  assign fail_pulse = arm & smp_rise & probe_q & ~pri_seen;

  // R10
  disarmed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !probe_q);
  // R4
  probe_set_by_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(probe_q) |-> $past(smp_rise));
endmodule

// File: rtl/cfg_ctrl.sv
`timescale 1ns/1ps
module cfg_ctrl
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] osc_mode,
  input  logic              ost_done,
  input  logic              pll_done,
  input  logic [SEL_W-1:0]  pm_sel,
  input  logic              pm_sel_wr,
  input  logic              flag_clr,
  input  logic              mon_en,
  input  logic              wake,
  input  logic              fail_pulse,
  output logic              arm,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              pri_en,
  output logic              fail_flag,
  output logic              osc_stable
);
  st_e              st_q, st_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             flag_q, flag_d;
  logic             timers_done;

  assign timers_done = ost_done & ((osc_mode != MODE_PLL) | pll_done);

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    if (wake) begin
      st_d = ST_BOOT;
    end else begin
      unique case (st_q)
        ST_BOOT: begin
          sel_d = SEL_PRI;
          st_d  = is_xtal(osc_mode) ? ST_START : ST_RUN;
        end
        ST_START: begin
          if (pm_sel_wr && norm_sel(pm_sel) != SEL_PRI) begin
            st_d  = ST_ALT;
            sel_d = norm_sel(pm_sel);
          end else if (timers_done) begin
            st_d  = ST_RUN;
            sel_d = SEL_PRI;
          end
        end
        ST_ALT: begin
          if (pm_sel_wr) begin
            if (norm_sel(pm_sel) == SEL_PRI) begin
              st_d  = ST_START;
              sel_d = SEL_PRI;
            end else begin
              sel_d = norm_sel(pm_sel);
            end
          end
        end
        ST_RUN: begin
          if (fail_pulse)     st_d  = ST_FAIL;
          else if (pm_sel_wr) sel_d = norm_sel(pm_sel);
        end
        ST_FAIL: begin
          if (pm_sel_wr) begin
            st_d  = ST_RUN;
            sel_d = norm_sel(pm_sel);
          end
        end
        default: st_d = ST_BOOT;
      endcase
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (fail_pulse && st_q == ST_RUN && !wake) flag_d = 1'b1;
    else if (flag_clr)                         flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_BOOT;
      sel_q  <= SEL_INT;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_ALT, ST_RUN: clk_sel = sel_q;
      default:        clk_sel = SEL_INT;
    endcase
  end

  assign arm        = (st_q == ST_RUN) && (sel_q == SEL_PRI) && mon_en;
  assign pri_en     = (st_q != ST_ALT);
  assign fail_flag  = flag_q;
  assign osc_stable = (st_q == ST_RUN);

  // R3
  start_on_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START) |-> (clk_sel == SEL_INT && !osc_stable));
  // R5
  flag_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_flag) |-> $past(arm));
  // R6
  no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAIL && !pm_sel_wr && !wake) |=> (clk_sel == SEL_INT));
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !flag_clr) |=> fail_flag);
  // R9
  alt_pri_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ALT) |-> (!pri_en && clk_sel != SEL_PRI));
  // R11
  wake_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (clk_sel == SEL_INT && !osc_stable));
endmodule

// File: rtl/clk_fail_guard.sv
`timescale 1ns/1ps
module clk_fail_guard
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              intosc_clk,
  input  logic              rst_n,
  input  logic              pri_clk,
  input  logic              smp_clk,
  input  logic [MODE_W-1:0] osc_mode,
  input  logic              ost_done,
  input  logic              pll_done,
  input  logic [SEL_W-1:0]  pm_sel,
  input  logic              pm_sel_wr,
  input  logic              flag_clr,
  input  logic              mon_en,
  input  logic              wake,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              pri_en,
  output logic              fail_flag,
  output logic              osc_stable
);
  logic rst_sync_n;
  logic arm;
  logic fail_pulse;

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(intosc_clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  cfg_probe #(.SYNC_STAGES(SYNC_STAGES)) u_probe (
    .clk(intosc_clk), .rst_n(rst_sync_n), .pri_rst_n(rst_n),
    .pri_clk(pri_clk), .smp_clk(smp_clk), .arm(arm),
    .fail_pulse(fail_pulse)
  );

  cfg_ctrl u_ctrl (
    .clk(intosc_clk), .rst_n(rst_sync_n), .osc_mode(osc_mode),
    .ost_done(ost_done), .pll_done(pll_done), .pm_sel(pm_sel),
    .pm_sel_wr(pm_sel_wr), .flag_clr(flag_clr), .mon_en(mon_en),
    .wake(wake), .fail_pulse(fail_pulse), .arm(arm),
    .clk_sel(clk_sel), .pri_en(pri_en), .fail_flag(fail_flag),
    .osc_stable(osc_stable)
  );
endmodule

// File: tb/clk_fail_guard_bench.sv
`timescale 1ns/1ps
module clk_fail_guard_bench;
  logic       intosc_clk = 1'b0;
  logic       rst_n;
  logic       pri_clk = 1'b0;
  logic       smp_clk = 1'b0;
  logic [2:0] osc_mode;
  logic       ost_done, pll_done;
  logic [1:0] pm_sel;
  logic       pm_sel_wr, flag_clr, mon_en, wake;
  logic [1:0] clk_sel;
  logic       pri_en, fail_flag, osc_stable;
  logic       pri_run = 1'b1;
  int         n_run = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;
  int unsigned sd;

  localparam int SMP = 50; // sample period in internal cycles

  clk_fail_guard u_clk_fail_guard (
    .intosc_clk(intosc_clk), .rst_n(rst_n), .pri_clk(pri_clk), .smp_clk(smp_clk),
    .osc_mode(osc_mode), .ost_done(ost_done), .pll_done(pll_done),
    .pm_sel(pm_sel), .pm_sel_wr(pm_sel_wr), .flag_clr(flag_clr),
    .mon_en(mon_en), .wake(wake), .clk_sel(clk_sel), .pri_en(pri_en),
    .fail_flag(fail_flag), .osc_stable(osc_stable)
  );

  always #4 intosc_clk = ~intosc_clk;
  always #200 smp_clk = ~smp_clk;
  initial forever begin
    #10;
    if (pri_run) pri_clk = ~pri_clk;
  end

  function automatic logic [1:0] exp_sel(logic [1:0] code);
    return code[1] ? 2'b10 : code;
  endfunction

  function automatic logic exp_xtal(logic [2:0] m);
    return m < 3'd4;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge intosc_clk);
    @(negedge intosc_clk);
  endtask

  task automatic pulse_wr(logic [1:0] code);
    @(negedge intosc_clk);
    pm_sel = code; pm_sel_wr = 1'b1;
    @(negedge intosc_clk);
    pm_sel_wr = 1'b0;
  endtask

  task automatic do_reset(logic [2:0] m, logic ost, logic pll, logic run);
    rst_n = 1'b0; osc_mode = m; ost_done = ost; pll_done = pll;
    pm_sel = 2'b00; pm_sel_wr = 1'b0; flag_clr = 1'b0; mon_en = 1'b1;
    wake = 1'b0; pri_run = run;
    cyc(4);
    rst_n = 1'b1;
    cyc(8);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    sd = $urandom(32'd4242);

    // R1 reset state, external-clock type
    do_reset(3'd4, 1'b0, 1'b0, 1'b1);
    chk("R1 clk_sel", clk_sel, 0);
    chk("R1 osc_stable", osc_stable, 1);
    chk("R1 pri_en", pri_en, 1);
    chk("R1 fail_flag", fail_flag, 0);

    // R4 running primary, no flag
    cyc(5*SMP);
    chk("R4 flag", fail_flag, 0);
    chk("R4 clk_sel", clk_sel, 0);

    // R5 mid-run stop
    pri_run = 1'b0;
    cyc(4*SMP);
    chk("R5 flag", fail_flag, 1);
    chk("R5 clk_sel", clk_sel, 2);

    // R6 primary resumes, no return
    pri_run = 1'b1;
    cyc(3*SMP);
    chk("R6 clk_sel", clk_sel, 2);

    // R7 clear flag keeps internal selection
    @(negedge intosc_clk); flag_clr = 1'b1;
    @(negedge intosc_clk); flag_clr = 1'b0;
    cyc(2);
    chk("R7 flag", fail_flag, 0);
    chk("R7 clk_sel", clk_sel, 2);

    // R8 select writes
    pulse_wr(2'b00); cyc(2);
    chk("R8 pri", clk_sel, exp_sel(2'b00));
    pulse_wr(2'b01); cyc(2);
    chk("R8 sec", clk_sel, exp_sel(2'b01));
    pri_run = 1'b0; cyc(4*SMP);
    chk("R8 sec unmonitored", fail_flag, 0);
    pri_run = 1'b1;
    pulse_wr(2'b11); cyc(2);
    chk("R8 int", clk_sel, exp_sel(2'b11));

    // R10 monitor disabled
    pulse_wr(2'b00);
    mon_en = 1'b0; pri_run = 1'b0;
    cyc(4*SMP);
    chk("R10 flag", fail_flag, 0);
    chk("R10 clk_sel", clk_sel, 0);
    pri_run = 1'b1; mon_en = 1'b1;

    // R11 wake keeps flag, restarts
    pri_run = 1'b0; cyc(4*SMP);
    pri_run = 1'b1; cyc(SMP);
    @(negedge intosc_clk); wake = 1'b1;
    @(negedge intosc_clk); wake = 1'b0;
    cyc(4);
    chk("R11 flag kept", fail_flag, 1);
    chk("R11 clk_sel", clk_sel, 0);

    // R3 crystal never starts
    do_reset(3'd1, 1'b0, 1'b0, 1'b0);
    cyc(5*SMP);
    chk("R3 flag", fail_flag, 0);
    chk("R3 osc_stable", osc_stable, 0);
    chk("R3 clk_sel", clk_sel, 2);

    // R2 crystal with PLL starts late
    do_reset(3'd3, 1'b1, 1'b0, 1'b0);
    cyc(2*SMP);
    chk("R2 pending stable", osc_stable, 0);
    chk("R2 pending sel", clk_sel, 2);
    pri_run = 1'b1; cyc(SMP);
    pll_done = 1'b1; cyc(3);
    chk("R2 handover sel", clk_sel, 0);
    chk("R2 handover stable", osc_stable, 1);
    cyc(4*SMP);
    chk("R2 no flag", fail_flag, 0);

    // R9 alternate selection during start-up
    do_reset(3'd2, 1'b0, 1'b0, 1'b0);
    pulse_wr(2'b01); cyc(2);
    chk("R9 pri_en", pri_en, 0);
    chk("R9 clk_sel", clk_sel, 1);

    // Random rounds: R4 / R5
    for (int r = 0; r < 8; r++) begin
      logic [2:0] m;
      logic stop;
      m = 3'd4 + 3'($urandom_range(0, 2));
      stop = 1'($urandom_range(0, 1));
      do_reset(m, 1'b1, 1'b1, 1'b1);
      cyc(SMP * (2 + $urandom_range(0, 3)));
      if (stop) pri_run = 1'b0;
      cyc(4*SMP);
      chk(stop ? "R5 rnd flag" : "R4 rnd flag", fail_flag, int'(stop));
      chk(stop ? "R5 rnd sel" : "R4 rnd sel", clk_sel,
          stop ? 2 : (exp_xtal(m) ? 2 : 0));
      pri_run = 1'b1;
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule